// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs management transactions to an Ethernet PHY over a two-wire serial link: a clock it divides down itself and a bidirectional data line. Software places a complete 32-bit command word in the data register. The word carries the start code, the opcode, the PHY address, the register address, the turnaround code and any write data. Writing the word starts a frame. The controller first sends 32 ones as a preamble and then shifts out the command word, most significant bit first.

For a read, the controller releases the data line during the turnaround. It then collects the 16 bits the PHY returns and places them in the low half of the data register. At the end of every frame it sets a completion flag, which software clears by writing a one to it.

The link clock rate comes from a divisor field held one bit up in the speed register. Software writes twice the divisor. A divisor of zero stops the link clock.

Top module: `mgmt_frame_ctrl`

## Requirements
- R1: After reset the data, speed and event registers read zero, the busy bit reads 0, MDC is low and the data-line output enable is low.
- R2: A bus write to the data register (select 0) while idle, with a nonzero divisor, starts a frame, and the busy bit (bit 0 of the event register, select 2) reads 1 in the next cycle.
- R3: The divisor N is held in bits 6:1 of the speed register (select 1), and bit 0 is not stored and reads 0. Each MDC half period lasts N system clock cycles, so MDC runs at f_sys / (2N).
- R4: A frame has 64 MDC rising edges. On the first 32 the data line carries 1. On rise 33+j it carries command bit 31-j. The line changes only while MDC is low.
- R5: A read command has bits 29:28 equal to 10. For a read, the output enable is low on rises 48 to 64, which carry command bits 16 down to 0, and high on all earlier rises. For any other opcode the enable is high on all 64 rises.
- R6: For a read, the line level at rises 49 to 64 is collected MSB first into data bits 15:0, and bits 31:16 keep their value. A line held high returns 0xFFFF.
- R7: A frame that is not a read leaves the data register unchanged.
- R8: Exactly 128*N cycles after the starting write, busy reads 0, event bit 23 reads 1 and MDC is low. One cycle earlier, busy still reads 1.
- R9: Writing the event register with bit 23 set clears the flag. Writing it with bit 23 clear leaves the flag as it was.
- R10: A data register write while busy has no effect: the register keeps its value and the frame in progress is unchanged.
- R11: With a divisor of zero, MDC stays low and a data register write stores the word but starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Register select: 0 data, 1 speed, 2 event/status |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The only register between a bus write and its effect is the one write edge, so busy, the speed readback and the event flag are read in the cycle right after the write. Completion falls exactly 128*N edges after the start write. The bench counts falling clock edges from that write, including the cycles spent on any extra bus write during the frame. It reads busy both one cycle before that point and at it. Serial bits, the enable and the PHY model's responses are tied to MDC edges rather than to cycle counts. The high-phase width is measured by counting the system clock falling edges on which MDC is high.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
    localparam int PRE_BITS     = 32;
    localparam int CMD_BITS     = 32;
    localparam int RSP_BITS     = 16;
    localparam int EVT_DONE_BIT = 23;
    localparam int BUSY_BIT     = 0;
    localparam int OP_HI        = CMD_BITS - 3;

    localparam logic [1:0] OP_READ = 2'b10;

    typedef enum logic [1:0] {
        SEL_DATA  = 2'd0,
        SEL_SPEED = 2'd1,
        SEL_EVENT = 2'd2
    } sel_e;
endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             tick_o
);
    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (half_i != '0) && ((cnt_q + ONE) == half_i);
        cnt_d  = (!run_i || tick_o) ? '0 : cnt_q + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: the phase counter never passes the half-period length
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && half_i != '0) |-> (cnt_q < half_i));
endmodule

// File: rtl/frame_engine.sv
module frame_engine
    import mgmt_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [CMD_BITS-1:0] cmd_i,
    input  logic [DIV_W-1:0]    half_i,
    input  logic                mdio_i,
    output logic                mdc_o,
    output logic                mdio_o,
    output logic                mdio_oe_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                rd_o,
    output logic [RSP_BITS-1:0] rsp_o
);
    localparam int FRAME_BITS = PRE_BITS + CMD_BITS;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int REL_IDX    = FRAME_BITS - RSP_BITS - 1;
    localparam int CAP_IDX    = FRAME_BITS - RSP_BITS;
    localparam int LAST_IDX   = FRAME_BITS - 1;

    typedef struct packed {
        logic                  busy;
        logic                  mdc;
        logic                  rd;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sh;
        logic [DIV_W-1:0]      half;
        logic [RSP_BITS-1:0]   cap;
    } eng_t;

    eng_t eng_d, eng_q;
    logic tick;

    mdc_divider #(.DIV_W(DIV_W)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (eng_q.busy),
        .half_i(eng_q.half),
        .tick_o(tick)
    );

    always_comb begin
        eng_d  = eng_q;
        done_o = 1'b0;
        if (!eng_q.busy) begin
            if (start_i && half_i != '0) begin
                eng_d.busy = 1'b1;
                eng_d.mdc  = 1'b0;
                eng_d.rd   = (cmd_i[OP_HI -: 2] == OP_READ);
                eng_d.idx  = '0;
                eng_d.sh   = {{PRE_BITS{1'b1}}, cmd_i};
                eng_d.half = half_i;
                eng_d.cap  = '0;
            end
        end else if (tick) begin
            if (!eng_q.mdc) begin
                eng_d.mdc = 1'b1;
                if (eng_q.rd && eng_q.idx >= IDX_W'(CAP_IDX))
                    eng_d.cap = {eng_q.cap[RSP_BITS-2:0], mdio_i};
            end else begin
                eng_d.mdc = 1'b0;
                if (eng_q.idx == IDX_W'(LAST_IDX)) begin
                    eng_d.busy = 1'b0;
                    done_o     = 1'b1;
                end else begin
                    eng_d.idx = eng_q.idx + IDX_W'(1);
                    eng_d.sh  = {eng_q.sh[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign mdc_o     = eng_q.mdc;
    assign mdio_o    = eng_q.busy ? eng_q.sh[FRAME_BITS-1] : 1'b1;
    assign mdio_oe_o = eng_q.busy && !(eng_q.rd && eng_q.idx >= IDX_W'(REL_IDX));
    assign busy_o    = eng_q.busy;
    assign rd_o      = eng_q.rd;
    assign rsp_o     = eng_q.cap;

    // R8: MDC rests low outside a frame
    p_mdc_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mdc_o);
    // R5: the line is not driven outside a frame
    p_oe_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mdio_oe_o);
    // R5: non-read frames drive the line throughout
    p_wr_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !rd_o) |-> mdio_oe_o);
    // R4: the data line holds still across a rising MDC edge
    p_rise_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc_o) |-> $stable(mdio_o));
    // R11: a zero divisor refuses to start a frame
    p_zero_div_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && half_i == '0) |=> !busy_o);
endmodule

// File: rtl/mgmt_frame_ctrl.sv
module mgmt_frame_ctrl
    import mgmt_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bus_sel,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    typedef struct packed {
        logic [CMD_BITS-1:0] data;
        logic [DIV_W-1:0]    spd;
        logic                evt;
    } regs_t;

    regs_t regs_d, regs_q;

    logic                busy, done, rd;
    logic [RSP_BITS-1:0] rsp;
    logic                wr_data, wr_spd, wr_evt, start;

    assign wr_data = bus_wr && (bus_sel == SEL_DATA);
    assign wr_spd  = bus_wr && (bus_sel == SEL_SPEED);
    assign wr_evt  = bus_wr && (bus_sel == SEL_EVENT);
    assign start   = wr_data && !busy;

    frame_engine #(.DIV_W(DIV_W)) eng_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .cmd_i    (bus_wdata),
        .half_i   (regs_q.spd),
        .mdio_i   (mdio_i),
        .mdc_o    (mdc),
        .mdio_o   (mdio_o),
        .mdio_oe_o(mdio_oe),
        .busy_o   (busy),
        .done_o   (done),
        .rd_o     (rd),
        .rsp_o    (rsp)
    );

    always_comb begin
        regs_d = regs_q;
        if (start)
            regs_d.data = bus_wdata;
        if (done && rd)
            regs_d.data[RSP_BITS-1:0] = rsp;
        if (wr_spd)
            regs_d.spd = bus_wdata[DIV_W:1];
        if (done)
            regs_d.evt = 1'b1;
        else if (wr_evt && bus_wdata[EVT_DONE_BIT])
            regs_d.evt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_sel)
            SEL_DATA:  bus_rdata = regs_q.data;
            SEL_SPEED: bus_rdata[DIV_W:0] = {regs_q.spd, 1'b0};
            SEL_EVENT: begin
                bus_rdata[EVT_DONE_BIT] = regs_q.evt;
                bus_rdata[BUSY_BIT]     = busy;
            end
            default:   bus_rdata = '0;
        endcase
    end

    // R10: a data write during a frame leaves the register alone
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_data && !done) |=> $stable(regs_q.data));
    // R8: frame end raises the completion flag
    p_event_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> regs_q.evt);
    // R9: write-one clears the flag
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.evt && wr_evt && bus_wdata[EVT_DONE_BIT] && !done) |=> !regs_q.evt);
    // R6: the collected response lands in the low half
    p_rd_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rd) |=> (regs_q.data[RSP_BITS-1:0] == $past(rsp)));
endmodule

// File: tb/mgmt_frame_ctrl_tb.sv
module mgmt_frame_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  bus_sel;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int   rise_cnt = 0;
    logic mo_bits [64];
    logic oe_bits [64];
    logic        phy_en  = 1'b0;
    logic        phy_rd  = 1'b0;
    logic [15:0] phy_val = 16'h0;

    always #5 clk = ~clk;

    mgmt_frame_ctrl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .mdc      (mdc),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .mdio_i   (mdio_i)
    );

    // record line state at each rising MDC edge
    always @(posedge mdc) begin
        mo_bits[rise_cnt % 64] = mdio_o;
        oe_bits[rise_cnt % 64] = mdio_oe;
        rise_cnt = rise_cnt + 1;
    end

    // simple PHY: present response bits while MDC is low
    always @(negedge mdc) begin
        int k;
        k = rise_cnt % 64;
        if (phy_en && phy_rd && k >= 48) mdio_i = phy_val[63 - k];
        else                             mdio_i = 1'b1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] sel, input logic [31:0] val);
        bus_sel   = sel;
        bus_wdata = val;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] sel, output logic [31:0] val);
        bus_sel = sel;
        #1;
        val = bus_rdata;
    endtask

    // called at the negedge after the start write; used = cycles already spent
    task automatic wait_done(input int n, input int used);
        logic [31:0] v;
        repeat (128 * n - 1 - used) @(negedge clk);
        bus_read(2'd2, v);
        check(v[0] == 1'b1, "R8 busy one cycle before end", v, 32'h1);
        @(negedge clk);
        bus_read(2'd2, v);
        check(v[0] == 1'b0 && v[23] == 1'b1, "R8 end of frame", v, 32'h0080_0000);
        check(mdc == 1'b0, "R8 mdc low at end", {31'b0, mdc}, 32'h0);
    endtask

    task automatic check_bits(input logic [31:0] cmd, input bit rd);
        int bad_o  = 0;
        int bad_oe = 0;
        for (int k = 0; k < 64; k++) begin
            logic eo, eoe;
            eo  = (k < 32) ? 1'b1 : cmd[63 - k];
            eoe = rd ? (k < 47) : 1'b1;
            if (oe_bits[k] !== eoe) bad_oe++;
            if (eoe && mo_bits[k] !== eo) bad_o++;
        end
        check(bad_o == 0, "R4 serial bit sequence", bad_o, 0);
        check(bad_oe == 0, "R5 output enable pattern", bad_oe, 0);
    endtask

    task automatic clear_event();
        bus_write(2'd2, 32'h0080_0000);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(2'd0, v); check(v == 0, "R1 data reset", v, 0);
        bus_read(2'd1, v); check(v == 0, "R1 speed reset", v, 0);
        bus_read(2'd2, v); check(v == 0, "R1 event/busy reset", v, 0);
        check(mdc == 0 && mdio_oe == 0, "R1 pins reset", {30'b0, mdc, mdio_oe}, 0);
    endtask

    task automatic t_zero_speed();
        logic [31:0] v;
        int rises;
        rises = rise_cnt;
        bus_write(2'd0, 32'h5002_1234);
        repeat (20) @(negedge clk);
        bus_read(2'd2, v);
        check(v[0] == 1'b0, "R11 no frame with zero divisor", v, 0);
        check(rise_cnt == rises && mdc == 1'b0, "R11 mdc held low", rise_cnt - rises, 0);
        bus_read(2'd0, v);
        check(v == 32'h5002_1234, "R11 word stored", v, 32'h5002_1234);
    endtask

    task automatic t_speed_field();
        logic [31:0] v;
        int hi;
        int guard;
        bus_write(2'd1, 32'h0000_0007);
        bus_read(2'd1, v);
        check(v == 32'h6, "R3 speed readback drops bit 0", v, 32'h6);
        bus_write(2'd0, 32'h5002_0000);
        @(posedge mdc);
        hi = 0;
        forever begin
            @(negedge clk);
            if (mdc) hi++;
            else break;
        end
        check(hi == 3, "R3 high phase length", hi, 3);
        guard = 0;
        do begin
            @(negedge clk);
            bus_read(2'd2, v);
            guard++;
        end while (v[0] && guard < 2000);
        check(v[23] == 1'b1, "R8 flag after divided frame", v, 32'h0080_0000);
        check_bits(32'h5002_0000, 1'b0);
        clear_event();
    endtask

    task automatic t_write_frame();
        logic [31:0] v;
        logic [31:0] cmd;
        cmd = 32'h5002_0000 | (32'd5 << 23) | (32'd3 << 18) | 32'h0000_A5C3;
        bus_write(2'd1, 32'h0000_0004);
        bus_write(2'd0, cmd);
        bus_read(2'd2, v);
        check(v[0] == 1'b1, "R2 busy after start", v, 32'h1);
        wait_done(2, 0);
        check_bits(cmd, 1'b0);
        bus_read(2'd0, v);
        check(v == cmd, "R7 write frame keeps data", v, cmd);
    endtask

    task automatic t_event_clear();
        logic [31:0] v;
        bus_write(2'd2, 32'h0000_0000);
        bus_read(2'd2, v);
        check(v[23] == 1'b1, "R9 zero write keeps flag", v, 32'h0080_0000);
        bus_write(2'd2, 32'h0080_0000);
        bus_read(2'd2, v);
        check(v[23] == 1'b0, "R9 one write clears flag", v, 0);
    endtask

    task automatic t_read_frame();
        logic [31:0] v;
        logic [31:0] cmd;
        cmd = 32'h6002_0000 | (32'd1 << 23) | (32'd2 << 18);
        phy_en = 1'b1; phy_rd = 1'b1; phy_val = 16'h3C5A;
        bus_write(2'd0, cmd);
        wait_done(2, 0);
        check_bits(cmd, 1'b1);
        bus_read(2'd0, v);
        check(v == {cmd[31:16], 16'h3C5A}, "R6 read response", v, {cmd[31:16], 16'h3C5A});
        phy_en = 1'b0; phy_rd = 1'b0;
        clear_event();
    endtask

    task automatic t_read_nophy();
        logic [31:0] v;
        logic [31:0] cmd;
        cmd = 32'h6002_0000 | (32'd31 << 23) | (32'd1 << 18);
        bus_write(2'd0, cmd);
        wait_done(2, 0);
        bus_read(2'd0, v);
        check(v == {cmd[31:16], 16'hFFFF}, "R6 idle line reads all ones", v, {cmd[31:16], 16'hFFFF});
        clear_event();
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        logic [31:0] cmd;
        cmd = 32'h5002_0000 | (32'd9 << 23) | (32'd17 << 18) | 32'h0000_0F0F;
        bus_write(2'd0, cmd);
        repeat (40) @(negedge clk);
        bus_write(2'd0, 32'hDEAD_BEEF);
        bus_read(2'd0, v);
        check(v == cmd, "R10 write during frame ignored", v, cmd);
        wait_done(2, 41);
        check_bits(cmd, 1'b0);
        bus_read(2'd0, v);
        check(v == cmd, "R10 data after frame", v, cmd);
        clear_event();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_sel = 2'd0; bus_wdata = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_speed();
        t_speed_field();
        t_write_frame();
        t_event_clear();
        t_read_frame();
        t_read_nophy();
        t_busy_ignore();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule